// File: doc/BRIEF.md
# Frame-Synchronised Serial Receiver with Overrun Flag

This block deserialises a frame-synchronised bit stream into fixed-length words. Data passes through three holding stages: a shift stage that assembles bits, a middle holding register, and a host-visible data register. A word moves forward only when the stage ahead of it is free. Once a word reaches the data register, a ready flag rises. Each rise of that flag also produces a one-cycle request pulse, so a DMA engine can fetch the word. If the host or DMA does not read the data register in time, all three stages fill up and a sticky overrun flag is raised.

The whole block runs on one system clock. The serial receive clock arrives as a one-cycle strobe, `rx_bit_stb`, that marks each rising receive-clock edge. The frame sync and the data pin are sampled on those strobes. A small register interface gives the host three things: the data read, a status word, and a receiver enable bit. Clearing the enable bit holds the receiver in reset.

Top module: `sr_rx_top`

## Requirements
- R1: After system reset, `rx_ready`, `dma_evt`, the status word and the data word all read 0. The receiver enable bit is 0, so the receiver starts in reset.
- R2: A strobe with `rx_fsync`=1 carries no data and arms a new word. The next W strobes shift `rx_din` in MSB first. The finished word reaches the data register, with `rx_ready`=1, within 3 clocks after the last bit strobe, provided the stages ahead are free.
- R3: The hand-off between stages is gated. A word moves from the shift stage to the holding register only when that register is empty or is being copied forward in the same cycle. The holding register is copied to the data register only while ready is 0. Words therefore leave in arrival order.
- R4: A read strobe at address 0 returns the data word and clears ready. A read at address 1 returns the status word and changes nothing.
- R5: The overrun flag (status bit 2) sets when three things hold at once: ready is 1, the holding register is full, and the shift stage holds a finished word. From an empty receiver, two words never set it and a third, unread, does. The flag is sticky.
- R6: During overrun, bits keep shifting in. A new word overwrites the word waiting in the shift stage, and the overwritten word is lost.
- R7: The overrun flag clears on a data read. It also clears when the enable bit is written to 0, which clears ready, empties all stages and zeroes the data word.
- R8: `dma_evt` is a one-clock pulse in the same cycle that ready rises. While ready stays high, including during overrun, no further pulse occurs.
- R9: The register map has two addresses. Address 0 is the data word. Address 1 is the status word: bit 0 is the enable bit (read/write, written from `ctl_en_wdata` when `reg_wr`=1 at address 1), bit 1 is ready and bit 2 is overrun. The upper bits read 0.
- R10: A frame sync in the middle of a word discards the partial word and starts a new one.
- R11: While the enable bit is 0, bit strobes are ignored: no word is assembled and ready stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit_stb | input | 1 | One-cycle strobe per rising receive-clock edge |
| rx_fsync | input | 1 | Frame sync, sampled on a bit strobe |
| rx_din | input | 1 | Serial data, sampled on a bit strobe |
| reg_addr | input | 1 | Register select: 0 data, 1 status/control |
| reg_wr | input | 1 | Write strobe |
| ctl_en_wdata | input | 1 | Enable bit value written at address 1 |
| reg_rd | input | 1 | Read strobe; at address 0 it consumes the data word |
| reg_rdata | output | W | Read data, combinational from `reg_addr` |
| rx_ready | output | 1 | Data register loaded and not yet read |
| dma_evt | output | 1 | One-cycle request on each rise of ready |

## Verification
On every cycle, the assertions check four things. Ready never drops without a data read or a receiver reset. Overrun is only ever raised when all three stages are full, and it never exists without ready. The data word changes only when a copy raises ready or when the receiver is reset. Every request pulse coincides with a rise of ready. Some behaviours only the bench scenarios can show, because they depend on whole sequences of words. These are which word is lost when overrun overwrites the shift stage, the order in which words are delivered after late reads, the effect of a resynchronising frame sync, and the count of requests compared with the number of words delivered.

// File: rtl/sr_rx_pkg.sv
package sr_rx_pkg;
    typedef enum logic {
        ADDR_DATA = 1'b0,
        ADDR_CTRL = 1'b1
    } rx_addr_e;

    localparam int STAT_EN_BIT  = 0;
    localparam int STAT_RDY_BIT = 1;
    localparam int STAT_OVR_BIT = 2;
    localparam int STAT_BITS    = 3;
endpackage

// File: rtl/sr_rx_shift.sv
module sr_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rcv_en,
    input  logic         bit_stb,
    input  logic         fsync,
    input  logic         din,
    input  logic         take,
    output logic [W-1:0] rsr,
    output logic         rsr_full
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     sr;
        logic             full;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rcv_en) begin
            st_d = '0;
        end else if (bit_stb && fsync) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
            if (take) st_d.full = 1'b0;
        end else if (bit_stb && st_q.armed) begin
            st_d.sr  = {st_q.sr[W-2:0], din};
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.full  = 1'b1;
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.full = 1'b0;
            end
        end else if (take) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsr      = st_q.sr;
    assign rsr_full = st_q.full;

    a_r2_full_after_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.full) |-> $past(bit_stb && st_q.armed && rcv_en));

    a_r11_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !rcv_en |=> !st_q.full && !st_q.armed);
endmodule

// File: rtl/sr_rx_stage.sv
module sr_rx_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rcv_en,
    input  logic [W-1:0] rsr,
    input  logic         rsr_full,
    input  logic         host_rd,
    output logic         take,
    output logic [W-1:0] drr,
    output logic         ready,
    output logic         overrun,
    output logic         dma_evt
);
    typedef struct packed {
        logic [W-1:0] rbr;
        logic         rbr_full;
        logic [W-1:0] drr;
        logic         ready;
        logic         ovr;
        logic         evt;
    } stage_st_t;

    stage_st_t st_d, st_q;
    logic copy_now;
    logic move_now;

    always_comb begin
        copy_now = rcv_en && st_q.rbr_full && !st_q.ready;
        move_now = rcv_en && rsr_full && (!st_q.rbr_full || copy_now);
        st_d     = st_q;
        st_d.evt = 1'b0;
        if (!rcv_en) begin
            st_d = '0;
        end else begin
            if (copy_now) begin
                st_d.drr      = st_q.rbr;
                st_d.ready    = 1'b1;
                st_d.rbr_full = 1'b0;
                st_d.evt      = 1'b1;
            end else if (host_rd) begin
                st_d.ready = 1'b0;
            end
            if (move_now) begin
                st_d.rbr      = rsr;
                st_d.rbr_full = 1'b1;
            end
            if (host_rd) begin
                st_d.ovr = 1'b0;
            end else if (st_q.ready && st_q.rbr_full && rsr_full) begin
                st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take    = move_now;
    assign drr     = st_q.drr;
    assign ready   = st_q.ready;
    assign overrun = st_q.ovr;
    assign dma_evt = st_q.evt;

    a_r4_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ready && !host_rd && rcv_en |=> st_q.ready);

    a_r5_ovr_needs_three: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovr) |-> $past(st_q.ready && st_q.rbr_full && rsr_full));

    a_r5_ovr_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovr |-> st_q.ready);

    a_r3_drr_only_on_copy: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.drr) |-> $rose(st_q.ready) || !$past(rcv_en));

    a_r8_evt_on_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |-> st_q.ready && !$past(st_q.ready));

    a_r8_rise_gives_evt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ready) |-> st_q.evt);
endmodule

// File: rtl/sr_rx_regif.sv
module sr_rx_regif #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_addr,
    input  logic         reg_wr,
    input  logic         wdata_en,
    input  logic         reg_rd,
    input  logic [W-1:0] drr,
    input  logic         ready,
    input  logic         overrun,
    output logic         rcv_en,
    output logic         host_rd,
    output logic [W-1:0] rdata
);
    import sr_rx_pkg::*;

    typedef struct packed {
        logic en;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic [STAT_BITS-1:0] stat;

    always_comb begin
        st_d = st_q;
        if (reg_wr && rx_addr_e'(reg_addr) == ADDR_CTRL) st_d.en = wdata_en;
        stat               = '0;
        stat[STAT_EN_BIT]  = st_q.en;
        stat[STAT_RDY_BIT] = ready;
        stat[STAT_OVR_BIT] = overrun;
        if (rx_addr_e'(reg_addr) == ADDR_DATA) rdata = drr;
        else                                   rdata = W'(stat);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rcv_en  = st_q.en;
    assign host_rd = reg_rd && (rx_addr_e'(reg_addr) == ADDR_DATA);

    a_r9_enable_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr |=> rcv_en == $past(wdata_en));
endmodule

// File: rtl/sr_rx_top.sv
module sr_rx_top #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_bit_stb,
    input  logic         rx_fsync,
    input  logic         rx_din,
    input  logic         reg_addr,
    input  logic         reg_wr,
    input  logic         ctl_en_wdata,
    input  logic         reg_rd,
    output logic [W-1:0] reg_rdata,
    output logic         rx_ready,
    output logic         dma_evt
);
    logic         rcv_en;
    logic         host_rd;
    logic         take;
    logic [W-1:0] rsr;
    logic         rsr_full;
    logic [W-1:0] drr;
    logic         overrun;

    sr_rx_shift #(.W(W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .rcv_en   (rcv_en),
        .bit_stb  (rx_bit_stb),
        .fsync    (rx_fsync),
        .din      (rx_din),
        .take     (take),
        .rsr      (rsr),
        .rsr_full (rsr_full)
    );

    sr_rx_stage #(.W(W)) i_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .rcv_en   (rcv_en),
        .rsr      (rsr),
        .rsr_full (rsr_full),
        .host_rd  (host_rd),
        .take     (take),
        .drr      (drr),
        .ready    (rx_ready),
        .overrun  (overrun),
        .dma_evt  (dma_evt)
    );

    sr_rx_regif #(.W(W)) i_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .wdata_en (ctl_en_wdata),
        .reg_rd   (reg_rd),
        .drr      (drr),
        .ready    (rx_ready),
        .overrun  (overrun),
        .rcv_en   (rcv_en),
        .host_rd  (host_rd),
        .rdata    (reg_rdata)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !rx_ready && !dma_evt);
endmodule

// File: tb/test_sr_rx_top.sv
module test_sr_rx_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_bit_stb = 1'b0;
    logic         rx_fsync = 1'b0;
    logic         rx_din = 1'b0;
    logic         reg_addr = 1'b0;
    logic         reg_wr = 1'b0;
    logic         ctl_en_wdata = 1'b0;
    logic         reg_rd = 1'b0;
    logic [W-1:0] reg_rdata;
    logic         rx_ready;
    logic         dma_evt;

    always #10 clk = ~clk;

    sr_rx_top #(.W(W)) i_sr_rx_top (
        .clk(clk), .rst_n(rst_n), .rx_bit_stb(rx_bit_stb), .rx_fsync(rx_fsync),
        .rx_din(rx_din), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .ctl_en_wdata(ctl_en_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .rx_ready(rx_ready), .dma_evt(dma_evt)
    );

    int n_chk = 0;
    int n_fail = 0;
    int dma_cnt = 0;
    bit done = 0;

    // expected-state model
    bit           m_en, m_rdy, m_ovr, m_rbr_has, m_rsr_has;
    logic [W-1:0] m_drr, m_rbr, m_rsr;
    int           m_evts;

    always @(posedge clk) if (rst_n && dma_evt) dma_cnt++;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_status();
        logic [W-1:0] s = '0;
        s[0] = m_en;
        s[1] = m_rdy;
        s[2] = m_ovr;
        return s;
    endfunction

    task automatic m_settle();
        for (int k = 0; k < 3; k++) begin
            if (m_rbr_has && !m_rdy) begin
                m_drr = m_rbr; m_rdy = 1; m_rbr_has = 0; m_evts++;
            end
            if (m_rsr_has && !m_rbr_has) begin
                m_rbr = m_rsr; m_rbr_has = 1; m_rsr_has = 0;
            end
        end
        if (m_rdy && m_rbr_has && m_rsr_has) m_ovr = 1;
    endtask

    task automatic m_clear();
        m_rdy = 0; m_ovr = 0; m_rbr_has = 0; m_rsr_has = 0;
        m_drr = '0; m_rbr = '0; m_rsr = '0;
    endtask

    task automatic strobe(input logic fs, input logic d);
        @(negedge clk);
        rx_bit_stb = 1; rx_fsync = fs; rx_din = d;
        @(negedge clk);
        rx_bit_stb = 0; rx_fsync = 0; rx_din = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send(input logic [W-1:0] v, input int nbits);
        strobe(1'b1, 1'b0);
        for (int i = 0; i < nbits; i++) strobe(1'b0, v[W-1-i]);
        repeat (4) @(negedge clk);
        if (m_en) begin
            if (nbits == W) begin m_rsr = v; m_rsr_has = 1; end
            else m_rsr_has = 0;
            m_settle();
        end
    endtask

    task automatic reg_read(input logic a, output logic [W-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0; reg_addr = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic write_en(input logic v);
        @(negedge clk);
        reg_addr = 1; reg_wr = 1; ctl_en_wdata = v;
        @(negedge clk);
        reg_wr = 0; reg_addr = 0; ctl_en_wdata = 0;
        repeat (3) @(negedge clk);
        m_en = v;
        if (!v) m_clear();
    endtask

    task automatic chk_status(string req);
        logic [W-1:0] d;
        reg_read(1'b1, d);
        check(req, 32'(d), 32'(exp_status()));
        check(req, 32'(rx_ready), 32'(m_rdy));
        check({req, " dma count"}, 32'(dma_cnt), 32'(m_evts));
    endtask

    task automatic chk_data(string req);
        logic [W-1:0] d;
        reg_read(1'b0, d);
        check(req, 32'(d), 32'(m_drr));
        m_rdy = 0; m_ovr = 0;
        m_settle();
    endtask

    initial begin
        int unsigned seed = 32'd20240611;
        void'($urandom(seed));
        m_en = 0; m_evts = 0; m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 32'(rx_ready), 0);
        check("R1 dma", 32'(dma_evt), 0);
        chk_status("R1 status");
        chk_data("R1 data");
        // R11 ignored while disabled
        send(16'hA5C3, W);
        chk_status("R11 disabled");
        write_en(1);
        chk_status("R9 enable bit");
        // R2 single element, MSB first
        send(16'h8001, W);
        chk_status("R2 ready after word");
        chk_status("R4 status read keeps ready");
        chk_data("R2 word value");
        chk_status("R4 ready cleared");
        // R5 two words do not overrun, third does
        send(16'h1111, W);
        send(16'h2222, W);
        chk_status("R5 two words no overrun");
        send(16'h3333, W);
        chk_status("R5 third word overrun");
        // R6 overwrite during overrun; R8 no extra event
        send(16'h4444, W);
        chk_status("R8 no event while ready high");
        chk_data("R7 read first word");
        chk_status("R7 overrun cleared by read");
        chk_data("R3 order second word");
        chk_data("R6 survivor word");
        chk_status("R6 stages empty");
        // R10 resync discards partial
        send(16'hFFFF, 8);
        send(16'h5A5A, W);
        chk_data("R10 resync word");
        // R7 receiver reset clears overrun
        send(16'h0101, W);
        send(16'h0202, W);
        send(16'h0303, W);
        chk_status("R5 overrun again");
        write_en(0);
        chk_status("R7 receiver reset clears");
        chk_data("R7 data zeroed");
        write_en(1);
        // random mix
        for (int it = 0; it < 250; it++) begin
            int unsigned op = $urandom % 8;
            if (op < 4)       send(W'($urandom), W);
            else if (op < 6)  chk_data("R3 random read");
            else if (op == 6) chk_status("R5 random status");
            else begin write_en(0); write_en(1); chk_status("R7 random reset"); end
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule